// File: doc/BRIEF.md
# Fault-Checking Bus Condition Generator

This block produces the START and STOP conditions of a two-wire open-drain serial bus (I2C) and confirms every line change it makes by reading the line back. Each drive step is held for a programmable settle time and then compared against what the line should read. This exposes a peripheral or a second master that is holding a line. A mismatch on the clock line is reported as a bus-lock error. A mismatch on the data line is reported as a data-stuck error. Before the START edge, the block also demands that both lines stay high over a programmable idle window.

The block keeps one bit of bus phase. After reset it waits for a START request. After a successful START it waits for a STOP request. A request that does not fit the current phase is refused without touching the lines. Line inputs are samples that have already been synchronised to the clock. The outputs are pull-down enables: 1 pulls the line low and 0 releases it. Shifting data bits is left to other logic.

Top module: `i2c_cond_gen`

## Requirements
- R1: After reset both pull enables are 0, `done` is 0, and the block expects a START request. `done` is never high for two cycles in a row.
- R2: A START request while a STOP is expected, or a STOP request while a START is expected, gives `done` on the next cycle with code 3 (bad state), and both pull enables keep their values.
- R3: An accepted request first waits for the clock line to read high. If it stays low for WAIT_LIMIT cycles, the operation ends with code 4 (timeout).
- R4: START step 1 pulls the clock line low. If it still reads high after settling, the code is 1 (bus lock).
- R5: START step 2 releases the data line with the clock held low. If data reads low after settling, the code is 2 (data stuck).
- R6: After START releases the clock line, both lines must read high on each of `window_len`+1 consecutive cycles. Any low sample ends the START with code 1.
- R7: The START edge pulls data low while the clock is released. If data reads high after settling, the code is 2. On success the code is 0, the clock line is released, data stays pulled, and a STOP is now expected.
- R8: STOP pulls the clock line low and checks it (code 1 if it reads high), then pulls data low and checks it (code 2 if it reads high).
- R9: STOP then releases the clock line. After settling, data reading high gives code 2; otherwise the clock reading low gives code 1.
- R10: STOP finally releases data. After settling, the clock reading low gives code 1; otherwise data reading low gives code 2. On success the code is 0, both enables are 0, and a START is expected.
- R11: Every error other than bad state releases both lines and returns the block to expecting a START.
- R12: Each drive step keeps the enables steady for `settle_len`+1 cycles before its check. A START takes 4·`settle_len`+`window_len` cycles more than with both set to 0, and a STOP takes 4·`settle_len` more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request for a START condition |
| stop_req | input | 1 | One-cycle request for a STOP condition |
| scl_in | input | 1 | Synchronised sample of the clock line |
| sda_in | input | 1 | Synchronised sample of the data line |
| settle_len | input | CNT_W | Settle cycles added after each drive step |
| window_len | input | CNT_W | Idle window length before the START edge |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| done | output | 1 | One-cycle pulse when an operation ends |
| err_code | output | 3 | Result code, valid while `done` is high |

## Verification
A wrong step pointer or check shows at the ports when an operation ends. A fault on a given line then yields the wrong result code, or the final enables do not match the expected START or STOP state, as soon as `done` pulses. A lost phase bit shows on the very next request: a valid request is refused with code 3, or a mismatched one is accepted. Settle or window counting errors change the end-to-end latency by a fixed number of cycles, so the bench compares latencies taken at different settings. Faults are injected both as lines stuck from the start and as lines that go wrong part-way through a sequence, so that each individual check step is reached.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    typedef enum logic [2:0] {
        ERR_OK        = 3'd0,
        ERR_BUS_LOCK  = 3'd1,
        ERR_SDA_STUCK = 3'd2,
        ERR_BAD_STATE = 3'd3,
        ERR_TIMEOUT   = 3'd4
    } err_e;

    // Ordered: START steps then STOP steps; the sequencer advances by +1.
    typedef enum logic [2:0] {
        STP_S_CLK_LOW,
        STP_S_DAT_FREE,
        STP_S_CLK_FREE,
        STP_S_DAT_LOW,
        STP_P_CLK_LOW,
        STP_P_DAT_LOW,
        STP_P_CLK_FREE,
        STP_P_DAT_FREE
    } step_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_WAIT,
        SEQ_DRIVE,
        SEQ_WINDOW
    } seq_e;

    typedef struct packed {
        logic clk_pull;
        logic dat_pull;
    } pull_t;

    function automatic pull_t step_pull(step_e s);
        pull_t p;
        case (s)
            STP_S_CLK_LOW:  p = '{clk_pull: 1'b1, dat_pull: 1'b0};
            STP_S_DAT_FREE: p = '{clk_pull: 1'b1, dat_pull: 1'b0};
            STP_S_CLK_FREE: p = '{clk_pull: 1'b0, dat_pull: 1'b0};
            STP_S_DAT_LOW:  p = '{clk_pull: 1'b0, dat_pull: 1'b1};
            STP_P_CLK_LOW:  p = '{clk_pull: 1'b1, dat_pull: 1'b1};
            STP_P_DAT_LOW:  p = '{clk_pull: 1'b1, dat_pull: 1'b1};
            STP_P_CLK_FREE: p = '{clk_pull: 1'b0, dat_pull: 1'b1};
            default:        p = '{clk_pull: 1'b0, dat_pull: 1'b0};
        endcase
        return p;
    endfunction

    // Readback verdict for a step once its settle time has elapsed.
    function automatic err_e step_verdict(step_e s, logic scl, logic sda);
        err_e e;
        e = ERR_OK;
        case (s)
            STP_S_CLK_LOW:  if (scl)  e = ERR_BUS_LOCK;
            STP_S_DAT_FREE: if (!sda) e = ERR_SDA_STUCK;
            STP_S_CLK_FREE: e = ERR_OK;
            STP_S_DAT_LOW:  if (sda)  e = ERR_SDA_STUCK;
            STP_P_CLK_LOW:  if (scl)  e = ERR_BUS_LOCK;
            STP_P_DAT_LOW:  if (sda)  e = ERR_SDA_STUCK;
            STP_P_CLK_FREE: begin
                if (sda)       e = ERR_SDA_STUCK;
                else if (!scl) e = ERR_BUS_LOCK;
            end
            default: begin
                if (!scl)      e = ERR_BUS_LOCK;
                else if (!sda) e = ERR_SDA_STUCK;
            end
        endcase
        return e;
    endfunction

    function automatic step_e step_after(step_e s);
        return step_e'(s + 3'd1);
    endfunction

    function automatic logic step_final(step_e s);
        return (s == STP_S_DAT_LOW) || (s == STP_P_DAT_FREE);
    endfunction

endpackage

// File: rtl/i2c_cond_timer.sv
module i2c_cond_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (load)
            count_q <= load_val;
        else if (count_q != '0)
            count_q <= count_q - 1'b1;
    end

    assign zero = (count_q == '0);
endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
    import i2c_cond_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int WAIT_LIMIT = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [CNT_W-1:0] settle_len,
    input  logic [CNT_W-1:0] window_len,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             done,
    output logic [2:0]       err_code
);
    localparam int WAIT_W = $clog2(WAIT_LIMIT + 1);

    seq_e              seq_q;
    step_e             step_q;
    pull_t             pull_q;
    logic              hold_q;
    logic              done_q;
    err_e              err_q;
    logic [WAIT_W-1:0] wait_q;
    err_e              verdict;
    logic              bus_idle;

    assign verdict  = step_verdict(step_q, scl_in, sda_in);
    assign bus_idle = scl_in && sda_in;

    always_comb begin
        tmr_load = 1'b0;
        case (seq_q)
            SEQ_WAIT:   tmr_load = scl_in;
            SEQ_DRIVE:  tmr_load = tmr_zero && (verdict == ERR_OK) && !step_final(step_q);
            SEQ_WINDOW: tmr_load = tmr_zero && bus_idle;
            default:    tmr_load = 1'b0;
        endcase
        tmr_val = (seq_q == SEQ_DRIVE && step_q == STP_S_CLK_FREE) ? window_len : settle_len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q  <= SEQ_IDLE;
            step_q <= STP_S_CLK_LOW;
            pull_q <= '0;
            hold_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= ERR_OK;
            wait_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (seq_q)
                SEQ_IDLE: begin
                    if (start_req) begin
                        if (!hold_q) begin
                            seq_q  <= SEQ_WAIT;
                            step_q <= STP_S_CLK_LOW;
                            wait_q <= '0;
                        end else begin
                            done_q <= 1'b1;
                            err_q  <= ERR_BAD_STATE;
                        end
                    end else if (stop_req) begin
                        if (hold_q) begin
                            seq_q  <= SEQ_WAIT;
                            step_q <= STP_P_CLK_LOW;
                            wait_q <= '0;
                        end else begin
                            done_q <= 1'b1;
                            err_q  <= ERR_BAD_STATE;
                        end
                    end
                end
                SEQ_WAIT: begin
                    if (scl_in) begin
                        seq_q  <= SEQ_DRIVE;
                        pull_q <= step_pull(step_q);
                    end else if (wait_q == WAIT_W'(WAIT_LIMIT - 1)) begin
                        seq_q  <= SEQ_IDLE;
                        done_q <= 1'b1;
                        err_q  <= ERR_TIMEOUT;
                        pull_q <= '0;
                        hold_q <= 1'b0;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                SEQ_DRIVE: begin
                    if (tmr_zero) begin
                        if (verdict != ERR_OK) begin
                            seq_q  <= SEQ_IDLE;
                            done_q <= 1'b1;
                            err_q  <= verdict;
                            pull_q <= '0;
                            hold_q <= 1'b0;
                        end else if (step_q == STP_S_CLK_FREE) begin
                            seq_q <= SEQ_WINDOW;
                        end else if (step_final(step_q)) begin
                            seq_q  <= SEQ_IDLE;
                            done_q <= 1'b1;
                            err_q  <= ERR_OK;
                            hold_q <= (step_q == STP_S_DAT_LOW);
                        end else begin
                            step_q <= step_after(step_q);
                            pull_q <= step_pull(step_after(step_q));
                        end
                    end
                end
                SEQ_WINDOW: begin
                    if (!bus_idle) begin
                        seq_q  <= SEQ_IDLE;
                        done_q <= 1'b1;
                        err_q  <= ERR_BUS_LOCK;
                        pull_q <= '0;
                        hold_q <= 1'b0;
                    end else if (tmr_zero) begin
                        seq_q  <= SEQ_DRIVE;
                        step_q <= STP_S_DAT_LOW;
                        pull_q <= step_pull(STP_S_DAT_LOW);
                    end
                end
                default: seq_q <= SEQ_IDLE;
            endcase
        end
    end

    assign scl_oe   = pull_q.clk_pull;
    assign sda_oe   = pull_q.dat_pull;
    assign done     = done_q;
    assign err_code = err_q;

    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_bad_state_keeps_lines_R2: assert property (@(posedge clk) disable iff (rst)
        (done && err_code == ERR_BAD_STATE) |-> ($stable(scl_oe) && $stable(sda_oe)));

    assert_wait_clock_free_R3: assert property (@(posedge clk) disable iff (rst)
        (seq_q == SEQ_WAIT) |-> !scl_oe);

    assert_window_lock_R6: assert property (@(posedge clk) disable iff (rst)
        (seq_q == SEQ_WINDOW && !bus_idle) |=> (done && err_code == ERR_BUS_LOCK));

    assert_ok_clock_free_R10: assert property (@(posedge clk) disable iff (rst)
        (done && err_code == ERR_OK) |-> !scl_oe);

    assert_error_release_R11: assert property (@(posedge clk) disable iff (rst)
        (done && err_code != ERR_OK && err_code != ERR_BAD_STATE) |-> (!scl_oe && !sda_oe));

    assert_settle_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (seq_q == SEQ_DRIVE && !tmr_zero) |=>
            (seq_q == SEQ_DRIVE && $stable(scl_oe) && $stable(sda_oe)));
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen #(
    parameter int CNT_W      = 8,
    parameter int WAIT_LIMIT = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [CNT_W-1:0] settle_len,
    input  logic [CNT_W-1:0] window_len,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             done,
    output logic [2:0]       err_code
);
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    i2c_cond_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    i2c_cond_seq #(.CNT_W(CNT_W), .WAIT_LIMIT(WAIT_LIMIT)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .settle_len (settle_len),
        .window_len (window_len),
        .tmr_zero   (tmr_zero),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .done       (done),
        .err_code   (err_code)
    );
endmodule

// File: tb/test_i2c_cond_gen.sv
module test_i2c_cond_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 8;

    // Fault codes: 0 none, 1 clock held low, 2 clock stuck high, 3 data held low, 4 data stuck high
    typedef struct packed {
        logic       is_stop;
        logic [2:0] flt;
        logic [2:0] exp_err;
        logic       exp_scl;
        logic       exp_sda;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 4'd7},   // R7 clean START
        '{1'b1, 3'd0, 3'd0, 1'b0, 1'b0, 4'd10},  // R10 clean STOP
        '{1'b0, 3'd1, 3'd4, 1'b0, 1'b0, 4'd3},   // R3 START timeout
        '{1'b0, 3'd2, 3'd1, 1'b0, 1'b0, 4'd4},   // R4 clock will not go low
        '{1'b0, 3'd3, 3'd2, 1'b0, 1'b0, 4'd5},   // R5 data held low
        '{1'b0, 3'd4, 3'd2, 1'b0, 1'b0, 4'd7},   // R7 data will not go low
        '{1'b1, 3'd2, 3'd1, 1'b0, 1'b0, 4'd8},   // R8 STOP clock will not go low
        '{1'b1, 3'd4, 3'd2, 1'b0, 1'b0, 4'd8},   // R8 STOP data will not go low
        '{1'b1, 3'd1, 3'd4, 1'b0, 1'b0, 4'd3},   // R3 STOP timeout
        '{1'b1, 3'd3, 3'd2, 1'b0, 1'b0, 4'd10}   // R10 data held low at the end
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_req = 1'b0;
    logic          stop_req = 1'b0;
    logic [CW-1:0] settle_len = 8'd2;
    logic [CW-1:0] window_len = 8'd4;
    logic          scl_oe, sda_oe, done;
    logic [2:0]    err_code;
    logic          scl_line, sda_line;
    int            fault = 0;
    int            checks = 0;
    int            fails = 0;
    bit            pend_stop = 1'b0;
    bit            finished = 1'b0;

    always_comb begin
        scl_line = (fault == 1) ? 1'b0 : (fault == 2) ? 1'b1 : !scl_oe;
        sda_line = (fault == 3) ? 1'b0 : (fault == 4) ? 1'b1 : !sda_oe;
    end

    i2c_cond_gen #(.CNT_W(CW), .WAIT_LIMIT(200)) i_i2c_cond_gen (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .scl_in     (scl_line),
        .sda_in     (sda_line),
        .settle_len (settle_len),
        .window_len (window_len),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .done       (done),
        .err_code   (err_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input bit is_stop);
        @(negedge clk);
        if (is_stop) stop_req = 1'b1; else start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        stop_req  = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 1;
        while (!done && lat < 5000) begin
            @(negedge clk);
            lat++;
        end
        if (!done) check(1'b0, "done-timeout", 0, 1);
    endtask

    task automatic wait_scl(input logic v);
        for (int k = 0; k < 5000 && scl_oe != v; k++) @(negedge clk);
    endtask

    task automatic clean_op(input bit is_stop, output int lat);
        pulse(is_stop);
        wait_done(lat);
        check(err_code == 3'd0, is_stop ? "R10 clean stop" : "R7 clean start", err_code, 0);
        pend_stop = !is_stop;
    endtask

    int lat, la, lb, lc, ld;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 pulls after reset", {scl_oe, sda_oe}, 0);
        check(done == 1'b0, "R1 done after reset", done, 0);

        // R2 STOP while a START is expected
        pulse(1'b1);
        wait_done(lat);
        check(err_code == 3'd3 && lat == 1, "R2 stop refused", err_code, 3);
        check(scl_oe == 1'b0 && sda_oe == 1'b0, "R2 lines kept", {scl_oe, sda_oe}, 0);
        @(negedge clk);
        check(done == 1'b0, "R1 done one cycle", done, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            if (v.is_stop && !pend_stop) clean_op(1'b0, lat);
            if (!v.is_stop && pend_stop) clean_op(1'b1, lat);
            fault = int'(v.flt);
            pulse(v.is_stop);
            wait_done(lat);
            fault = 0;
            check(err_code == v.exp_err, $sformatf("R%0d vector %0d code", v.req, i), err_code, v.exp_err);
            check(scl_oe == v.exp_scl && sda_oe == v.exp_sda,
                  $sformatf("R%0d vector %0d pulls", v.req, i), {scl_oe, sda_oe}, {v.exp_scl, v.exp_sda});
            pend_stop = !v.is_stop && (v.exp_err == 3'd0);
        end

        // R2 START while a STOP is expected
        settle_len = 8'd0;
        if (!pend_stop) clean_op(1'b0, lat);
        pulse(1'b0);
        wait_done(lat);
        check(err_code == 3'd3, "R2 start refused", err_code, 3);
        check(scl_oe == 1'b0 && sda_oe == 1'b1, "R2 lines kept", {scl_oe, sda_oe}, 1);
        clean_op(1'b1, lat);

        // R6 data pulled low during the idle window
        window_len = 8'd20;
        pulse(1'b0);
        wait_scl(1'b1);
        wait_scl(1'b0);
        fault = 3;
        wait_done(lat);
        fault = 0;
        check(err_code == 3'd1, "R6 window lock", err_code, 1);
        window_len = 8'd2;

        // R9 clock held low once STOP releases it
        clean_op(1'b0, lat);
        pulse(1'b1);
        wait_scl(1'b1);
        fault = 1;
        wait_done(lat);
        fault = 0;
        check(err_code == 3'd1, "R9 clock low after release", err_code, 1);

        // R9 data high once STOP releases the clock
        clean_op(1'b0, lat);
        pulse(1'b1);
        wait_scl(1'b1);
        wait_scl(1'b0);
        fault = 4;
        wait_done(lat);
        fault = 0;
        check(err_code == 3'd2, "R9 data high after clock release", err_code, 2);

        // R10 clock low at the final data release
        clean_op(1'b0, lat);
        pulse(1'b1);
        wait_scl(1'b1);
        for (int k = 0; k < 5000 && sda_oe; k++) @(negedge clk);
        fault = 1;
        wait_done(lat);
        fault = 0;
        check(err_code == 3'd1, "R10 clock low at end", err_code, 1);
        check(scl_oe == 1'b0 && sda_oe == 1'b0, "R11 lines released", {scl_oe, sda_oe}, 0);

        // R11 an error returns the phase to START-expected
        pulse(1'b1);
        wait_done(lat);
        check(err_code == 3'd3, "R11 phase after error", err_code, 3);
        pend_stop = 1'b0;

        // R12 latency grows with settle and window lengths
        settle_len = 8'd0; window_len = 8'd0;
        clean_op(1'b0, la);
        clean_op(1'b1, lb);
        settle_len = 8'd3; window_len = 8'd5;
        clean_op(1'b0, lc);
        clean_op(1'b1, ld);
        check(lc - la == 17, "R12 start latency delta", lc - la, 17);
        check(ld - lb == 12, "R12 stop latency delta", ld - lb, 12);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule